// File: doc/BRIEF.md
# Six-Bit GPIO Port with Stop-Mode Pin Retention

This block is a six-bit general-purpose I/O port controlled over a small synchronous register bus. Software programs an output latch, a per-pin direction and a per-pin pullup enable, and reads back either the live pin levels or the latch contents. Two of the six pins have a fixed role. Pin 5 only receives, and pin 4 only drives.

The port also follows the chip's three stop modes, which a two-bit mode input selects together with a one-cycle stop request and a one-cycle wake pulse. The light mode leaves everything as it was. The deep mode wipes the port back to its reset state. The partial power-down mode freezes the pad drive exactly as it stood on entry and discards the register contents. After wake-up, software sees a recovery flag set. It can rebuild the registers while the pins stay frozen, and it then writes an acknowledge bit to hand the pins back to the registers.

Top module: `gpio_retention_port`

## Requirements
- R1: After reset the data, direction and pullup registers read 0, the recovery flag reads 0, and pin_out, pin_oe and pin_pu are all 0.
- R2: For pins 0 to 4, pin_oe follows the direction bit and pin_out follows the data bit. Pin 5 always has pin_oe = 0 and pin_out = 0.
- R3: The pullup for a pin is active (pin_pu = 1) only when its pullup enable bit is 1 and its pin_oe is 0. pin_pu[4] is always 0.
- R4: A read of offset 0 returns, for bits 0 to 3, the data latch bit when its direction bit is 1 and the pin_in bit when it is 0.
- R5: A read of offset 0 returns pin_in[5] in bit 5 and the data latch in bit 4, whatever their direction bits hold. Bits 7:6 of every read are 0.
- R6: The register offsets are 0 data, 1 direction, 2 pullup enable and 3 power control. The power control read returns the recovery flag in bit 0 and 0 elsewhere. A write takes effect on the clock edge that samples it.
- R7: A stop request with stop_mode = 2'b11 clears all registers and drives every pin output to 0 from the next cycle on. After the wake pulse, the recovery flag reads 0.
- R8: A stop request with stop_mode = 2'b10 clears the registers from the next cycle on. pin_out, pin_oe and pin_pu keep the values they had in the request cycle.
- R9: A wake pulse after a stop_mode = 2'b10 stop sets the recovery flag to 1 from the next cycle on. A wake from any other stop mode leaves it at 0.
- R10: While the pins are held, register writes update the registers as seen on read-back, but pin_out, pin_oe and pin_pu stay frozen.
- R11: Writing 1 to bit 1 of offset 3 while the pins are held releases the hold and clears the recovery flag on that edge. From the next cycle the registers drive the pins. When nothing is held, the same write changes nothing.
- R12: A stop request with stop_mode[1] = 0 (light mode) leaves registers, pins and the recovery flag unchanged through stop and wake.
- R13: Bus writes are ignored in the cycle a stop request is accepted and while the port is stopped. Stop requests while stopped, and wake pulses while running, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| stop_req | input | 1 | One-cycle stop request |
| stop_mode | input | 2 | Stop mode, sampled with stop_req |
| wake | input | 1 | One-cycle wake pulse |
| pin_in | input | 6 | Sampled pad levels |
| pin_out | output | 6 | Pad output values |
| pin_oe | output | 6 | Pad output enables |
| pin_pu | output | 6 | Pad pullup enables |

## Verification
The assertions assume that stop_req and wake arrive as isolated one-cycle pulses and that stop_mode is valid whenever stop_req is high. Pin inputs and bus traffic may take any value. The bench keeps to these assumptions: it raises each pulse for a single cycle and chooses stop_mode in the same cycle. It also lets random stop requests and wakes arrive in any state, so the ignored cases in R13 are exercised as well. Held intervals are entered at random register contents, and the bench keeps writing during the hold, so the frozen drive is compared against registers that have since changed.

// File: rtl/gpio_ret_pkg.sv
package gpio_ret_pkg;
    localparam int PORT_W       = 6;
    localparam int BUS_W        = 8;
    localparam int ADDR_W       = 2;
    localparam int IN_ONLY_BIT  = 5;
    localparam int OUT_ONLY_BIT = 4;
    localparam int ACK_BIT      = 1;
    localparam int FLAG_BIT     = 0;

    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_PULL = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_PWR  = 2'd3;

    localparam logic [1:0] MODE_PARTIAL = 2'b10;
    localparam logic [1:0] MODE_DEEP    = 2'b11;

    typedef enum logic [1:0] {
        PWR_RUN,
        PWR_LIGHT,
        PWR_PARTIAL,
        PWR_DEEP
    } pwr_state_e;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] pull;
    } port_regs_t;

    typedef struct packed {
        logic [PORT_W-1:0] out;
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] pu;
    } pad_drive_t;
endpackage

// File: rtl/gpio_ret_regs.sv
module gpio_ret_regs
    import gpio_ret_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [PORT_W-1:0]  wdata,
    input  logic               clear,
    output port_regs_t         regs
);
    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (clear) begin
            regs_d = '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_DATA: regs_d.data = wdata;
                OFS_DIR:  regs_d.dir  = wdata;
                OFS_PULL: regs_d.pull = wdata;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R8: register contents are lost on entry to a power-down stop
    assert_regs_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (regs_q == '0));
endmodule

// File: rtl/gpio_ret_pad_mux.sv
module gpio_ret_pad_mux
    import gpio_ret_pkg::*;
(
    input  port_regs_t         regs,
    input  logic [PORT_W-1:0]  pin_in,
    output pad_drive_t         live_drv,
    output logic [PORT_W-1:0]  data_rd
);
    logic [PORT_W-1:0] out_v, oe_v, pu_v, rd_v;

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (i == IN_ONLY_BIT) begin : g_in_only
            assign out_v[i] = 1'b0;
            assign oe_v[i]  = 1'b0;
            assign pu_v[i]  = regs.pull[i];
            assign rd_v[i]  = pin_in[i];
        end else if (i == OUT_ONLY_BIT) begin : g_out_only
            assign out_v[i] = regs.data[i];
            assign oe_v[i]  = regs.dir[i];
            assign pu_v[i]  = 1'b0;
            assign rd_v[i]  = regs.data[i];
        end else begin : g_bidir
            assign out_v[i] = regs.data[i];
            assign oe_v[i]  = regs.dir[i];
            assign pu_v[i]  = regs.pull[i] & ~regs.dir[i];
            assign rd_v[i]  = regs.dir[i] ? regs.data[i] : pin_in[i];
        end
    end

    assign live_drv.out = out_v;
    assign live_drv.oe  = oe_v;
    assign live_drv.pu  = pu_v;
    assign data_rd      = rd_v;
endmodule

// File: rtl/gpio_ret_lowpower.sv
module gpio_ret_lowpower
    import gpio_ret_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_req,
    input  logic [1:0]  stop_mode,
    input  logic        wake,
    input  logic        ack_wr,
    input  pad_drive_t  live_drv,
    output pad_drive_t  pin_drv,
    output logic        recov_flag,
    output logic        asleep,
    output logic        clear_regs
);
    typedef struct packed {
        pwr_state_e  state;
        logic        hold;
        logic        flag;
        pad_drive_t  frozen;
    } lp_state_t;

    lp_state_t lp_d, lp_q;
    logic      running;

    assign running = (lp_q.state == PWR_RUN);
    assign pin_drv = lp_q.hold ? lp_q.frozen : live_drv;

    always_comb begin
        lp_d       = lp_q;
        clear_regs = 1'b0;
        if (running) begin
            if (stop_req) begin
                if (stop_mode == MODE_DEEP) begin
                    lp_d.state  = PWR_DEEP;
                    lp_d.hold   = 1'b0;
                    lp_d.flag   = 1'b0;
                    lp_d.frozen = '0;
                    clear_regs  = 1'b1;
                end else if (stop_mode == MODE_PARTIAL) begin
                    lp_d.state  = PWR_PARTIAL;
                    lp_d.hold   = 1'b1;
                    lp_d.flag   = 1'b0;
                    lp_d.frozen = pin_drv;
                    clear_regs  = 1'b1;
                end else begin
                    lp_d.state  = PWR_LIGHT;
                end
            end else if (ack_wr && lp_q.hold) begin
                lp_d.hold = 1'b0;
                lp_d.flag = 1'b0;
            end
        end else if (wake) begin
            lp_d.state = PWR_RUN;
            if (lp_q.state == PWR_PARTIAL) lp_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lp_q <= '0;
        else        lp_q <= lp_d;
    end

    assign recov_flag = lp_q.flag;
    assign asleep     = !running;

    // R10: a held pad drive never moves while the hold persists
    assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_q.hold && $past(lp_q.hold)) |-> $stable(pin_drv));

    // R9: the flag only comes up on a wake out of the partial power-down
    assert_flag_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_q.flag) |-> $past(lp_q.state == PWR_PARTIAL && wake));

    // R11: an acknowledge while held releases the hold and clears the flag
    assert_ack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_q.hold && ack_wr && running && !stop_req) |=> (!lp_q.hold && !lp_q.flag));
endmodule

// File: rtl/gpio_retention_port.sv
module gpio_retention_port
    import gpio_ret_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic               stop_req,
    input  logic [1:0]         stop_mode,
    input  logic               wake,
    input  logic [PORT_W-1:0]  pin_in,
    output logic [PORT_W-1:0]  pin_out,
    output logic [PORT_W-1:0]  pin_oe,
    output logic [PORT_W-1:0]  pin_pu
);
    port_regs_t        regs;
    pad_drive_t        live_drv, pin_drv;
    logic [PORT_W-1:0] data_rd;
    logic              asleep, clear_regs, recov_flag;
    logic              wr_ok, ack_wr;

    assign wr_ok  = bus_sel && bus_wr && !asleep && !stop_req;
    assign ack_wr = wr_ok && (bus_addr == OFS_PWR) && bus_wdata[ACK_BIT];

    gpio_ret_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok),
        .addr  (bus_addr),
        .wdata (bus_wdata[PORT_W-1:0]),
        .clear (clear_regs),
        .regs  (regs)
    );

    gpio_ret_pad_mux u_mux (
        .regs     (regs),
        .pin_in   (pin_in),
        .live_drv (live_drv),
        .data_rd  (data_rd)
    );

    gpio_ret_lowpower u_lp (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .stop_mode  (stop_mode),
        .wake       (wake),
        .ack_wr     (ack_wr),
        .live_drv   (live_drv),
        .pin_drv    (pin_drv),
        .recov_flag (recov_flag),
        .asleep     (asleep),
        .clear_regs (clear_regs)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_DATA: bus_rdata[PORT_W-1:0] = data_rd;
            OFS_DIR:  bus_rdata[PORT_W-1:0] = regs.dir;
            OFS_PULL: bus_rdata[PORT_W-1:0] = regs.pull;
            default:  bus_rdata[FLAG_BIT]   = recov_flag;
        endcase
    end

    assign pin_out = pin_drv.out;
    assign pin_oe  = pin_drv.oe;
    assign pin_pu  = pin_drv.pu;

    // R7: a deep stop leaves every pad undriven and without pullup
    assert_deep_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && stop_req && stop_mode == MODE_DEEP) |=>
            (pin_out == '0 && pin_oe == '0 && pin_pu == '0));

    // R12: a light stop leaves the pads untouched
    assert_light_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && stop_req && !stop_mode[1]) |=>
            ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)));

    // R2: the input-only pin is never driven
    assert_in_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[IN_ONLY_BIT] && !pin_out[IN_ONLY_BIT]);
endmodule

// File: tb/gpio_retention_port_tb.sv
module gpio_retention_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stop_req = 1'b0, wake = 1'b0;
    logic [1:0] stop_mode = '0;
    logic [5:0] pin_in = '0;
    logic [5:0] pin_out, pin_oe, pin_pu;

    int checks = 0;
    int fails  = 0;

    // independent model state
    logic [5:0]  m_data = '0, m_dir = '0, m_pull = '0;
    logic        m_hold = 1'b0, m_flag = 1'b0;
    logic [17:0] m_frz = '0;
    int          m_state = 0; // 0 run, 1 light, 2 partial, 3 deep

    always #10 clk = ~clk;

    gpio_retention_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_req(stop_req), .stop_mode(stop_mode), .wake(wake),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    function automatic logic [17:0] live_pins();
        logic [5:0] o, e, p;
        for (int i = 0; i < 6; i++) begin
            o[i] = (i == 5) ? 1'b0 : m_data[i];
            e[i] = (i == 5) ? 1'b0 : m_dir[i];
            p[i] = (i == 4) ? 1'b0 : (m_pull[i] & ~e[i]);
        end
        return {o, e, p};
    endfunction

    function automatic logic [17:0] exp_pins();
        return m_hold ? m_frz : live_pins();
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        logic [7:0] r = '0;
        case (a)
            2'd0: begin
                for (int i = 0; i < 4; i++) r[i] = m_dir[i] ? m_data[i] : pin_in[i];
                r[4] = m_data[4];
                r[5] = pin_in[5];
            end
            2'd1: r[5:0] = m_dir;
            2'd2: r[5:0] = m_pull;
            default: r[0] = m_flag;
        endcase
        return r;
    endfunction

    function automatic void model_clock();
        logic wr = bus_sel && bus_wr;
        if (m_state == 0) begin
            if (stop_req) begin
                if (stop_mode == 2'b11) begin
                    m_state = 3; m_hold = 0; m_flag = 0; m_frz = '0;
                    m_data = '0; m_dir = '0; m_pull = '0;
                end else if (stop_mode == 2'b10) begin
                    m_frz = exp_pins(); m_state = 2; m_hold = 1; m_flag = 0;
                    m_data = '0; m_dir = '0; m_pull = '0;
                end else m_state = 1;
            end else if (wr) begin
                case (bus_addr)
                    2'd0: m_data = bus_wdata[5:0];
                    2'd1: m_dir  = bus_wdata[5:0];
                    2'd2: m_pull = bus_wdata[5:0];
                    default: if (bus_wdata[1] && m_hold) begin m_hold = 0; m_flag = 0; end
                endcase
            end
        end else if (wake) begin
            if (m_state == 2) m_flag = 1;
            m_state = 0;
        end
    endfunction

    task automatic chk(input string tag, input string what, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [17:0] e = exp_pins();
        chk(tag, "pin_out", {12'd0, pin_out}, {12'd0, e[17:12]});
        chk(tag, "pin_oe",  {12'd0, pin_oe},  {12'd0, e[11:6]});
        chk(tag, "pin_pu",  {12'd0, pin_pu},  {12'd0, e[5:0]});
        chk(tag, "rdata",   {10'd0, bus_rdata}, {10'd0, exp_read(bus_addr)});
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; stop_req = 0; wake = 0;
        #1 check_all(tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step(tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        bus_addr = a; #1 check_all(tag);
    endtask

    task automatic stop(input logic [1:0] m, input string tag);
        stop_req = 1; stop_mode = m; step(tag);
    endtask

    task automatic do_wake(input string tag);
        wake = 1; step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [17:0] held;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        for (int a = 0; a < 4; a++) rd(2'(a), "R1");
        rst_n = 1;
        step("R1");
        for (int a = 0; a < 4; a++) rd(2'(a), "R1");

        // register map and drive
        wr(2'd1, 8'h1F, "R6");
        wr(2'd0, 8'hF5, "R6");
        wr(2'd2, 8'h3F, "R3");
        rd(2'd1, "R6"); rd(2'd2, "R6"); rd(2'd3, "R6");
        wr(2'd1, 8'h05, "R2");
        wr(2'd0, 8'h3A, "R2");
        for (int k = 0; k < 6; k++) begin
            pin_in = 6'(k * 11 + 7);
            rd(2'd0, "R4");
            rd(2'd0, "R5");
        end
        wr(2'd1, 8'h3F, "R5");   // direction bit 5 set: still reads pin
        pin_in = 6'h20; rd(2'd0, "R5");
        wr(2'd1, 8'h00, "R5");   // direction bit 4 clear: still reads latch
        pin_in = 6'h00; rd(2'd0, "R5");
        wr(2'd1, 8'h0F, "R3");

        // ack with nothing held
        wr(2'd3, 8'h02, "R11");
        rd(2'd3, "R11");

        // light stop with ignored write and ignored wake before stop
        do_wake("R13");
        stop(2'b01, "R12");
        wr(2'd0, 8'h00, "R13");
        stop(2'b11, "R13");
        rd(2'd0, "R13");
        do_wake("R12");
        rd(2'd3, "R12");

        // partial power-down
        wr(2'd1, 8'h1B, "R8");
        wr(2'd0, 8'h16, "R8");
        held = exp_pins();
        stop(2'b10, "R8");
        chk("R8", "held", {pin_out, pin_oe, pin_pu}, held);
        rd(2'd1, "R8");
        do_wake("R9");
        rd(2'd3, "R9");
        wr(2'd1, 8'h00, "R10");
        wr(2'd2, 8'h3F, "R10");
        chk("R10", "held", {pin_out, pin_oe, pin_pu}, held);
        rd(2'd2, "R10");
        wr(2'd3, 8'h02, "R11");
        rd(2'd3, "R11");
        chk("R11", "released", {pin_out, pin_oe, pin_pu}, live_pins());

        // deep stop
        wr(2'd1, 8'h3F, "R7");
        wr(2'd0, 8'h3F, "R7");
        stop(2'b11, "R7");
        chk("R7", "pins", {pin_out, pin_oe, pin_pu}, 18'd0);
        do_wake("R7");
        rd(2'd3, "R9");
        rd(2'd0, "R7");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(99);
            pin_in   = 6'($urandom);
            bus_addr = 2'($urandom);
            if (op < 45) begin
                bus_sel = 1; bus_wr = 1; bus_wdata = 8'($urandom);
            end else if (op < 53) begin
                stop_req = 1; stop_mode = 2'($urandom);
            end else if (op < 63) begin
                wake = 1;
            end
            step(op < 45 ? "R6" : (op < 53 ? "R8" : "R9"));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule